// File: doc/BRIEF.md
# Low-Power Mode Entry Controller

This block sequences a small microcontroller between its run state and four reduced-power states. Software issues a single write to a mode-control register that carries three request bits (sleep, stop, and a "keep main clocks" bit whose 0 value requests time-base-timer mode). A clock-source select bit, owned by a separate clock register, decides which of the two sleep variants is used. The controller captures the write, decodes it one cycle later with a fixed priority, and moves to the chosen mode unless an enabled interrupt request is pending, in which case the request is dropped and the core keeps running.

In the sleep variants only the CPU clock is gated; peripheral clocks and the time-base clock keep running. Time-base-timer mode also gates the peripheral clock. Stop mode gates every clock. While the block is in any mode other than run, a pin-hold output tells the general-purpose pad logic to freeze non-bus pins at their present levels. Bus data and bus control pads do not use this signal. Any enabled interrupt request brings the block back to run on the next clock edge. Reset also returns it to run.

Request bits are write-triggered. They can be read back for the one cycle in which they are decoded and then clear to 0, whether the request was taken or rejected.

Top module: `lp_mode_ctrl`

## Requirements
- R1: After reset the mode output is run (code 0), the CPU, peripheral and time-base clock enables are 1, pin_hold is 0, and both request read-back bits are 0.
- R2: A write with sleep=1, stop=0 and keep-clocks=1 enters PLL-sleep (code 1) when main_sel=0 and main-sleep (code 2) when main_sel=1. The new mode is visible after the second rising edge that follows the write cycle.
- R3: Stop=1 in a write takes priority over the other bits and enters stop mode (code 4).
- R4: Keep-clocks=0 in a write without stop takes priority over sleep and enters time-base-timer mode (code 3).
- R5: A write with sleep=0, stop=0 and keep-clocks=1 leaves the block in run.
- R6: If any irq_req bit whose irq_en bit is also 1 is high in the decode cycle, the request is rejected and the mode stays run. Requests with irq_en=0 do not block entry.
- R7: In any non-run mode, an enabled interrupt request returns the mode to run on the next rising edge. Without one, the mode does not change.
- R8: Clock enables by mode: run gives all three at 1. Both sleeps give CPU 0, peripheral 1, time-base 1. Timer mode gives CPU 0, peripheral 0, time-base 1. Stop gives all three at 0.
- R9: pin_hold is 1 exactly when the mode is not run.
- R10: The read-back bits show the written sleep and stop values in the decode cycle and read 0 after it. This applies whether the request was taken or rejected.
- R11: Writes are ignored while the mode is not run. The mode is unchanged and the read-back bits stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Mode-control register write strobe |
| wr_sleep | input | 1 | Written sleep request bit |
| wr_stop | input | 1 | Written stop request bit |
| wr_keep_clk | input | 1 | Written keep-clocks bit (0 requests timer mode) |
| main_sel | input | 1 | Clock source select: 0 PLL, 1 main oscillator |
| irq_req | input | N_IRQ | Interrupt request lines |
| irq_en | input | N_IRQ | Per-line interrupt enables |
| mode | output | 3 | Current mode code (0 run, 1 PLL-sleep, 2 main-sleep, 3 timer, 4 stop) |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| tbt_clk_en | output | 1 | Time-base timer clock enable |
| pin_hold | output | 1 | Hold request for non-bus pins |
| rd_sleep | output | 1 | Sleep bit read-back |
| rd_stop | output | 1 | Stop bit read-back |

## Verification
Mode-entry decode and the interrupt blocking check share one cycle. A request is being decoded on the same edge at which an interrupt line may be asserted. The bench raises enabled and disabled interrupt lines exactly in the decode cycle of a sleep or stop write. It then judges that the mode stays run for an enabled line and that entry proceeds for a disabled one, and in both cases that the read-back bits clear. A second overlap is a write arriving while the block already sleeps. The bench checks that such a write neither changes the mode nor reaches the read-back bits.

// File: rtl/lp_mode_ctrl.sv
module lp_mode_ctrl #(
  parameter int N_IRQ = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sleep,
  input  logic             wr_stop,
  input  logic             wr_keep_clk,
  input  logic             main_sel,
  input  logic [N_IRQ-1:0] irq_req,
  input  logic [N_IRQ-1:0] irq_en,
  output logic [2:0]       mode,
  output logic             cpu_clk_en,
  output logic             per_clk_en,
  output logic             tbt_clk_en,
  output logic             pin_hold,
  output logic             rd_sleep,
  output logic             rd_stop
);
  localparam logic [2:0] M_RUN   = 3'd0;
  localparam logic [2:0] M_PSLP  = 3'd1;
  localparam logic [2:0] M_MSLP  = 3'd2;
  localparam logic [2:0] M_TIMER = 3'd3;
  localparam logic [2:0] M_STOP  = 3'd4;

  logic       req_v, req_sleep, req_stop, req_keep;
  logic [2:0] mode_q, mode_d;
  logic       irq_hit, running;

  assign irq_hit = |(irq_req & irq_en);
  assign running = (mode_q == M_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_v     <= 1'b0;
      req_sleep <= 1'b0;
      req_stop  <= 1'b0;
      req_keep  <= 1'b1;
    end else begin
      req_v     <= wr_en && running;
      req_sleep <= wr_en && running && wr_sleep;
      req_stop  <= wr_en && running && wr_stop;
      req_keep  <= !(wr_en && running) || wr_keep_clk;
    end
  end

  always_comb begin
    mode_d = mode_q;
    if (!running) begin
      if (irq_hit) mode_d = M_RUN;
    end else if (req_v && !irq_hit) begin
      if (req_stop)       mode_d = M_STOP;
      else if (!req_keep) mode_d = M_TIMER;
      else if (req_sleep) mode_d = main_sel ? M_MSLP : M_PSLP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= M_RUN;
    else        mode_q <= mode_d;
  end

  assign mode       = mode_q;
  assign cpu_clk_en = running;
  assign per_clk_en = running || mode_q == M_PSLP || mode_q == M_MSLP;
  assign tbt_clk_en = mode_q != M_STOP;
  assign pin_hold   = !running;
  assign rd_sleep   = req_sleep;
  assign rd_stop    = req_stop;

  // R7
  wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && irq_hit) |=> mode == M_RUN);
  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !irq_hit) |=> $stable(mode));
  // R6
  reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && req_v && irq_hit) |=> mode == M_RUN);
  // R3
  stop_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && req_v && req_stop && !irq_hit) |=> mode == M_STOP);
  // R10
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_v && !wr_en) |=> (!rd_sleep && !rd_stop));
  // R11
  ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && wr_en) |=> (!rd_sleep && !rd_stop));
  // R8
  always_comb begin
    if (rst_n) clk_order_chk: assert (!per_clk_en || tbt_clk_en);
  end
endmodule

// File: tb/tb_lp_mode_ctrl.sv
module tb_lp_mode_ctrl;
  localparam int TCLK = 10;
  localparam int NI = 4;
  localparam int NV = 10;

  // {sleep, stop, keep, main_sel, irq[3:0], en[3:0], exp_mode[2:0]}
  localparam logic [14:0] VEC [NV] = '{
    {1'b1,1'b0,1'b1,1'b0,4'b0000,4'b1111,3'd1},
    {1'b1,1'b0,1'b1,1'b1,4'b0000,4'b1111,3'd2},
    {1'b1,1'b1,1'b1,1'b0,4'b0000,4'b1111,3'd4},
    {1'b1,1'b0,1'b0,1'b0,4'b0000,4'b1111,3'd3},
    {1'b1,1'b1,1'b0,1'b1,4'b0000,4'b1111,3'd4},
    {1'b0,1'b0,1'b1,1'b0,4'b0000,4'b1111,3'd0},
    {1'b1,1'b0,1'b1,1'b0,4'b0001,4'b0001,3'd0},
    {1'b1,1'b0,1'b1,1'b0,4'b0010,4'b0001,3'd1},
    {1'b0,1'b1,1'b1,1'b0,4'b1000,4'b1000,3'd0},
    {1'b0,1'b0,1'b0,1'b1,4'b0000,4'b1111,3'd3}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, wr_sleep = 0, wr_stop = 0, wr_keep_clk = 1, main_sel = 0;
  logic [NI-1:0] irq_req = '0, irq_en = '0;
  logic [2:0] mode;
  logic cpu_clk_en, per_clk_en, tbt_clk_en, pin_hold, rd_sleep, rd_stop;
  int total = 0, bad = 0;
  bit done = 0;

  lp_mode_ctrl #(.N_IRQ(NI)) dut (.*);

  always #(TCLK/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] clk_exp(input logic [2:0] m);
    case (m)
      3'd0: return 3'b111;
      3'd1, 3'd2: return 3'b011;
      3'd3: return 3'b001;
      default: return 3'b000;
    endcase
  endfunction

  task automatic chk_outs(input logic [2:0] m, input string tag);
    logic [2:0] e = clk_exp(m);
    chk({cpu_clk_en, per_clk_en, tbt_clk_en} == e, {tag, " R8 clocks"},
        int'({cpu_clk_en, per_clk_en, tbt_clk_en}), int'(e));
    chk(pin_hold == (m != 3'd0), {tag, " R9 pin_hold"}, int'(pin_hold), int'(m != 3'd0));
  endtask

  task automatic do_write(input logic s, input logic p, input logic k, input logic ms);
    @(negedge clk);
    wr_en = 1; wr_sleep = s; wr_stop = p; wr_keep_clk = k; main_sel = ms;
    @(negedge clk);
    wr_en = 0; wr_sleep = 0; wr_stop = 0; wr_keep_clk = 1;
  endtask

  task automatic wake();
    irq_en = '1; irq_req = 4'b0100;
    @(negedge clk);
    irq_req = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(mode == 3'd0, "R1 mode in reset", int'(mode), 0);
    rst_n = 1;
    @(negedge clk);
    chk(mode == 3'd0, "R1 mode after reset", int'(mode), 0);
    chk(!rd_sleep && !rd_stop, "R1 readback", int'({rd_sleep, rd_stop}), 0);
    chk_outs(3'd0, "R1");

    for (int i = 0; i < NV; i++) begin
      logic [14:0] v = VEC[i];
      do_write(v[14], v[13], v[12], v[11]);
      irq_req = v[10:7]; irq_en = v[6:3];
      chk(rd_sleep == v[14] && rd_stop == v[13], $sformatf("R10 readback vec%0d", i),
          int'({rd_sleep, rd_stop}), int'({v[14], v[13]}));
      @(negedge clk);
      chk(mode == v[2:0], $sformatf("R2 R3 R4 R5 R6 mode vec%0d", i), int'(mode), int'(v[2:0]));
      chk(!rd_sleep && !rd_stop, $sformatf("R10 cleared vec%0d", i),
          int'({rd_sleep, rd_stop}), 0);
      chk_outs(v[2:0], $sformatf("vec%0d", i));
      irq_req = '0;
      if (v[2:0] != 3'd0) begin
        repeat (3) @(negedge clk);
        chk(mode == v[2:0], $sformatf("R7 stays vec%0d", i), int'(mode), int'(v[2:0]));
        wake();
        chk(mode == 3'd0, $sformatf("R7 wake vec%0d", i), int'(mode), 0);
        chk_outs(3'd0, "R7 after wake");
      end
    end

    do_write(1, 0, 1, 1);
    irq_en = 4'b0000; irq_req = 4'b1111;
    @(negedge clk);
    chk(mode == 3'd2, "R6 disabled irq no block", int'(mode), 2);
    repeat (2) @(negedge clk);
    chk(mode == 3'd2, "R7 disabled irq no wake", int'(mode), 2);
    irq_req = '0;
    do_write(0, 1, 1, 0);
    chk(!rd_stop && !rd_sleep, "R11 readback while asleep", int'({rd_sleep, rd_stop}), 0);
    @(negedge clk);
    chk(mode == 3'd2, "R11 write ignored while asleep", int'(mode), 2);
    wake();
    chk(mode == 3'd0, "R7 wake main sleep", int'(mode), 0);

    do_write(0, 1, 0, 0);
    @(negedge clk);
    chk(mode == 3'd4, "R3 stop over timer", int'(mode), 4);
    chk_outs(3'd4, "R8 stop");
    rst_n = 0;
    @(negedge clk);
    chk(mode == 3'd0, "R1 reset exits stop", int'(mode), 0);
    chk_outs(3'd0, "R1 reset");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog R1 actual=0 expected=1");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule